// File: doc/BRIEF.md
# Watchdog Timer with Selectable Reset Scope

This block is the watchdog of a small microcontroller. It runs entirely on the system oscillator clock. A free-running prescaler makes single-cycle tick enables at four rates. A two-bit field picks one of these ticks to advance a 4-bit watchdog counter. Software must service the watchdog, through a write to a clear register, before the counter passes its last value. If software does not, the block sets a sticky timeout flag and raises a reset request for a fixed number of cycles.

A scope bit in the control register sets the kind of reset request. One kind asks for a reset of the whole system. The other asks for a reset of only the program counter and the interrupt-enable state. The timeout flag is cleared only by the block's own hardware reset or by an explicit software clear. It therefore survives either kind of watchdog-requested reset, and firmware can use it to tell that the last restart came from a timeout. A static enable input switches the watchdog on or off as a whole.

Top module: `wdog_scope`

## Requirements
- R1: After hardware reset (`rst` high), both reset-request outputs are low, the control register reads 0x00 and the timeout flag is 0.
- R2: Control register (address 0) layout: bits 1:0 are the tick select, bit 2 is the scope bit, bit 7 reads the timeout flag, and bits 6:3 read 0. A write stores only bits 2:0.
- R3: The clear register (address 1) always reads 0x00.
- R4: With tick select value s, the counter advances once every 2^(TAP_LSB+3-s) oscillator cycles. With the default TAP_LSB of 14 these periods are 131072, 65536, 32768 and 16384 cycles for s = 0, 1, 2 and 3. An overflow occurs on the 16th tick after the counter was last zero.
- R5: On an overflow with scope bit 0, `sys_rst_req` is high for exactly 4 cycles starting the cycle after the overflow, and `core_rst_req` stays low.
- R6: On an overflow with scope bit 1, `core_rst_req` is high for exactly 4 cycles, and `sys_rst_req` stays low. The two outputs are never high together.
- R7: The timeout flag is set by an overflow and then stays set. Only `rst` or a write to the clear register with bit 7 = 1 clears it. A write to control bit 7 does not change it.
- R8: A write to the clear register with bit 7 = 1 sets the watchdog counter to zero, and it takes priority over a tick in the same cycle. A write to the clear register with bit 7 = 0 has no effect.
- R9: While `wdt_en` is low, the counter is held at zero, so no overflow and no reset request occur.
- R10: After an overflow the counter restarts from zero, so with no servicing the overflows repeat exactly 16 tick periods apart.
- R11: Servicing does not reset the prescaler, so the first timeout after a service lasts between 15 tick periods plus one cycle and 16 tick periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wdt_en | input | 1 | Static watchdog enable option |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 clear |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 clear |
| rd_data | output | 8 | Registered read data, valid one cycle after `rd_addr` |
| sys_rst_req | output | 1 | Whole-system reset request pulse |
| core_rst_req | output | 1 | Program-counter and interrupt-enable reset request pulse |

## Verification
The embedded properties check, on every cycle, that the two request outputs are never high together, that every overflow starts a request pulse and sets the flag, that the flag holds until it is cleared, and that servicing or disabling leaves the counter at zero. Some behaviour can only be shown by the bench's scenarios, using a behavioural cycle model of the prescaler phase. These are the exact timeout length for each tick select, the shortened first period after a service, the 4-cycle pulse width, and the read-back encodings.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int  REG_W    = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_CLR  = 1'b1;
  localparam int  STAT_BIT = 7;
  localparam int  SVC_BIT  = 7;
  localparam int  SCOPE_BIT = 2;
  localparam int  SEL_W    = 2;

  typedef enum logic {
    SCOPE_FULL = 1'b0,
    SCOPE_CORE = 1'b1
  } scope_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int TAP_LSB = 14,
  parameter int NTAPS   = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [NTAPS-1:0] tick_o
);
  localparam int PW = TAP_LSB + NTAPS - 1;

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // tap k fires once every 2^(TAP_LSB+k) cycles, registered
  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tick_o[k] <= 1'b0;
      else     tick_o[k] <= &div_q[TAP_LSB+k-1:0];
    end
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic svc,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = en && tick && !svc && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst || svc || !en) cnt_q <= '0;
    else if (tick)         cnt_q <= cnt_q + 1'b1;
  end

  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt_q == '0);
  // R8
  svc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    svc |=> cnt_q == '0);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  input  logic             ovf,
  output logic [REG_W-1:0] rd_data,
  output logic             svc_o,
  output logic             stat_o,
  output scope_e           scope_o,
  output logic [SEL_W-1:0] sel_o
);
  logic   stat_q;
  scope_e scope_q;
  logic [SEL_W-1:0] sel_q;
  logic   wr_data_unused;

  assign wr_data_unused = ^wr_data[REG_W-2:SCOPE_BIT+1];
  assign svc_o   = wr_en && (wr_addr == ADDR_CLR) && wr_data[SVC_BIT];
  assign stat_o  = stat_q;
  assign scope_o = scope_q;
  assign sel_o   = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= 1'b0;
      scope_q <= SCOPE_FULL;
      sel_q   <= '0;
      rd_data <= '0;
    end else begin
      if (svc_o)    stat_q <= 1'b0;
      else if (ovf) stat_q <= 1'b1;
      if (wr_en && wr_addr == ADDR_CTRL) begin
        scope_q <= scope_e'(wr_data[SCOPE_BIT]);
        sel_q   <= wr_data[SEL_W-1:0];
      end
      if (rd_addr == ADDR_CLR) rd_data <= '0;
      else rd_data <= {stat_q, {(REG_W-SCOPE_BIT-2){1'b0}}, scope_q, sel_q};
    end
  end

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q && !svc_o |=> stat_q);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   ovf,
  input  scope_e scope,
  output logic   sys_o,
  output logic   core_o
);
  localparam int LW = $clog2(PULSE_LEN + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      sys_o  <= 1'b0;
      core_o <= 1'b0;
    end else if (ovf) begin
      left_q <= LW'(PULSE_LEN - 1);
      sys_o  <= (scope == SCOPE_FULL);
      core_o <= (scope == SCOPE_CORE);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      sys_o  <= 1'b0;
      core_o <= 1'b0;
    end
  end

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (sys_o || core_o));
  // R6
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sys_o && core_o));
endmodule

// File: rtl/wdog_scope.sv
module wdog_scope
  import wdog_pkg::*;
#(
  parameter int TAP_LSB   = 14,
  parameter int CNT_W     = 4,
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wdt_en,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic       sys_rst_req,
  output logic       core_rst_req
);
  localparam int NTAPS = 1 << SEL_W;

  logic [NTAPS-1:0] tick_vec;
  logic             tick_sel;
  logic             ovf;
  logic             svc;
  logic             stat;
  scope_e           scope;
  logic [SEL_W-1:0] sel;

  wdog_prescale #(.TAP_LSB(TAP_LSB), .NTAPS(NTAPS)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick_vec)
  );

  // select 0 picks the slowest tap, select 3 the fastest
  assign tick_sel = tick_vec[SEL_W'(NTAPS-1) - sel];

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(wdt_en), .tick(tick_sel), .svc(svc), .ovf_o(ovf)
  );

  wdog_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ovf(ovf), .rd_data(rd_data), .svc_o(svc),
    .stat_o(stat), .scope_o(scope), .sel_o(sel)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .ovf(ovf), .scope(scope),
    .sys_o(sys_rst_req), .core_o(core_rst_req)
  );

  // R7
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> stat);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !wdt_en |-> !ovf);
endmodule

// File: tb/wdog_scope_tb.sv
module wdog_scope_tb;
  localparam int TAPL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wdt_en = 1'b0, wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic sys_rst_req, core_rst_req;

  always #4 clk = ~clk;

  wdog_scope #(.TAP_LSB(TAPL)) u_dut (
    .clk(clk), .rst(rst), .wdt_en(wdt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sys_rst_req(sys_rst_req), .core_rst_req(core_rst_req)
  );

  int vectors = 0, errors = 0, cyc = 0;
  // behavioural model state
  int p = 0, wc = 0, pl = 0;
  bit tq [4];
  bit st = 0, rs = 0, pk = 0;
  bit [1:0] cs = 0;
  bit [7:0] mrd = 0;

  always @(posedge clk) begin
    if (rst) begin
      p = 0; wc = 0; pl = 0; st = 0; rs = 0; pk = 0; cs = 0; mrd = 0;
      for (int k = 0; k < 4; k++) tq[k] = 0;
    end else begin
      bit clr, ovf, t;
      t = tq[3 - cs];
      clr = wr_en && wr_addr && wr_data[7];
      ovf = 0;
      if (clr || !wdt_en) wc = 0;
      else if (t) begin
        if (wc == 15) begin ovf = 1; wc = 0; end
        else wc++;
      end
      mrd = rd_addr ? 8'h00 : {st, 4'b0000, rs, cs};
      if (clr) st = 0; else if (ovf) st = 1;
      if (ovf) begin pl = 4; pk = rs; end
      else if (pl > 0) pl--;
      if (wr_en && !wr_addr) begin rs = wr_data[2]; cs = wr_data[1:0]; end
      for (int k = 0; k < 4; k++) tq[k] = ((p + 1) % (1 << (TAPL + k))) == 0;
      p++;
    end
  end

  // per-cycle compare and pulse monitor
  int sys_rises = 0, core_rises = 0, sys_rise_at = 0, core_rise_at = 0;
  int sys_run = 0, core_run = 0, sys_w = 0, core_w = 0;
  logic prev_sys = 0, prev_core = 0;

  always @(negedge clk) begin
    cyc++;
    vectors++;
    if (sys_rst_req !== (pl > 0 && !pk) || core_rst_req !== (pl > 0 && pk) ||
        rd_data !== mrd) begin
      errors++;
      $display("FAIL model R4/R5/R6: cyc %0d act sys=%b core=%b rd=%h exp sys=%b core=%b rd=%h",
               cyc, sys_rst_req, core_rst_req, rd_data, (pl > 0 && !pk), (pl > 0 && pk), mrd);
    end
    if (sys_rst_req && !prev_sys) begin sys_rises++; sys_rise_at = cyc; end
    if (core_rst_req && !prev_core) begin core_rises++; core_rise_at = cyc; end
    if (sys_rst_req) sys_run++; else if (sys_run > 0) begin sys_w = sys_run; sys_run = 0; end
    if (core_rst_req) core_run++; else if (core_run > 0) begin core_w = core_run; core_run = 0; end
    prev_sys = sys_rst_req;
    prev_core = core_rst_req;
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %0d (0x%0h) exp %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit a, bit [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic rd(bit a, output bit [7:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_sys(int n);
    while (sys_rises < n) @(negedge clk);
  endtask

  task automatic wait_core(int n);
    while (core_rises < n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    idle(150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    bit [7:0] v;
    int t1, t2, c0, base;
    idle(4);
    rst = 0;
    idle(1);
    // R1
    check("R1 sys", sys_rst_req, 0);
    check("R1 core", core_rst_req, 0);
    rd(0, v); check("R1 ctrl", v, 8'h00);
    // R2 / R7: bit7 and 6:3 not writable
    wr(0, 8'hFB);
    rd(0, v); check("R2 ctrl layout", v, 8'h03);
    // R3
    wr(1, 8'h7F);
    rd(1, v); check("R3 clr reads 0", v, 8'h00);
    rd(0, v); check("R8 clr bit7=0 no effect", v, 8'h03);
    // R9: disabled for longer than any timeout
    idle(600);
    check("R9 no sys pulse", sys_rises, 0);
    check("R9 no core pulse", core_rises, 0);
    rd(0, v); check("R9 flag clear", v, 8'h03);
    // R4/R10 fastest select, full scope
    wdt_en = 1;
    wait_sys(1); t1 = sys_rise_at;
    wait_sys(2); t2 = sys_rise_at;
    check("R10 repeat interval sel3", t2 - t1, 64);
    idle(6);
    check("R5 sys width", sys_w, 4);
    check("R5 core stays low", core_rises, 0);
    rd(0, v); check("R7 flag set", v, 8'h83);
    wr(0, 8'h83);
    rd(0, v); check("R7 ctrl bit7 write no effect", v, 8'h83);
    wr(1, 8'h80);
    rd(0, v); check("R7 flag cleared", v, 8'h03);
    // R8 servicing holds off timeout
    base = sys_rises;
    for (int i = 0; i < 10; i++) begin wr(1, 8'h80); idle(38); end
    check("R8 serviced no pulse", sys_rises, base);
    // R11 first period after a service is short
    @(negedge clk); c0 = cyc;
    wr_en = 1; wr_addr = 1; wr_data = 8'h80;
    @(negedge clk); wr_en = 0; wr_data = 8'h00;
    wait_sys(base + 1);
    vectors++;
    if (sys_rise_at - c0 < 61 || sys_rise_at - c0 > 64) begin
      errors++;
      $display("FAIL R11: act %0d exp 61..64", sys_rise_at - c0);
    end
    // R8: clear write with bit7=0 does not service
    base = sys_rises;
    for (int i = 0; i < 4; i++) begin wr(1, 8'h7F); idle(38); end
    check("R8 bit7=0 no service", sys_rises > base, 1);
    // R6 core scope
    wr(0, 8'h07);
    base = sys_rises;
    wait_core(1);
    idle(6);
    check("R6 core width", core_w, 4);
    check("R6 no sys pulse", sys_rises, base);
    // R4 select 1 (256) and select 0 (512)
    wr(0, 8'h01); wr(1, 8'h80);
    base = sys_rises;
    wait_sys(base + 1); t1 = sys_rise_at;
    wait_sys(base + 2); t2 = sys_rise_at;
    check("R4 interval sel1", t2 - t1, 256);
    wr(0, 8'h00); wr(1, 8'h80);
    base = sys_rises;
    wait_sys(base + 1); t1 = sys_rise_at;
    wait_sys(base + 2); t2 = sys_rise_at;
    check("R4 interval sel0", t2 - t1, 512);
    // R1 hardware reset clears the flag
    @(negedge clk); rst = 1;
    idle(3);
    @(negedge clk); rst = 0;
    rd(0, v); check("R1 flag cleared by rst", v, 8'h00);
    idle(4);
    summary();
  end
endmodule